// File: doc/BRIEF.md
# Microcoded Branch Sequencer

This block is a small microprogrammed controller. An 8-bit program counter fetches 16-bit words from a 256-entry instruction store. A word either loads a 15-bit registered control bank or makes a conditional jump. A conditional jump tests one of 16 condition inputs, picked by a 4-bit field. It jumps either when that condition is 1 or when it is 0, as the instruction chooses. One condition slot is forced true inside the block, so that slot gives an unconditional jump.

The instruction is fetched combinationally from the store at the current counter value. The counter and the control bank both update on the same rising edge. A synchronous write port loads the microprogram, normally while the block is held in reset. The active-low reset asserts asynchronously and is released through a two-stage synchronizer.

Top module: `micro_sequencer`

## Requirements
- R1: Driving rst_n_i low clears ctrl_o to zero at once, without waiting for a clock edge, and returns the counter to address 0. After rst_n_i rises, ctrl_o stays zero through the first two rising edges. The instruction at address 0 executes at the third rising edge.
- R2: A word with bit 15 = 0 is an output instruction. At the rising edge, its bits 14..0 appear on ctrl_o and the counter advances by one.
- R3: A word with bit 15 = 1 is a jump. Bit 14 is the wanted polarity, bits 13..10 select the condition slot and bits 7..0 give the target. When the selected condition equals the polarity, the counter loads the target; otherwise it advances by one. The condition is sampled in the cycle the jump executes.
- R4: Bits 9..8 of a jump word have no effect on where execution goes.
- R5: During a jump instruction, ctrl_o keeps its previous value.
- R6: Condition slot 15 always reads 1, whatever cond_i[15] is driven to.
- R7: Advancing from address 255 gives address 0.
- R8: With wr_en_i high, wr_data_i is stored at wr_addr_i on the rising edge. If that address is the one being executed in the same cycle, the old word executes. The new word takes effect the next time that address is fetched.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_n_i | input | 1 | Asynchronous active-low reset, released synchronously |
| cond_i | input | 16 | Condition inputs; slot 15 is overridden to 1 |
| ctrl_o | output | 15 | Registered control bank |
| wr_en_i | input | 1 | Instruction store write enable |
| wr_addr_i | input | 8 | Instruction store write address |
| wr_data_i | input | 16 | Instruction word to store |

## Verification
Two functions can land in the same cycle: a store write and the fetch of that same address. The bench provokes this by writing a new word to address 1 in the very cycle the counter sits on address 1. It then judges that the old word drives ctrl_o at that edge, and that the new word appears only after a jump loops back to address 1. The jump logic is swept over every selector value, both polarities and both values of the selected condition, with the other condition inputs driven opposite to it. This sweep catches a wrong slot choice or an inverted polarity. The sweep also drives slot 15 low to show the override.

// File: rtl/seq_pkg.sv
package seq_pkg;
  // Fixed part of the instruction layout
  localparam int SPARE_W  = 2;
  localparam int PC_W_DEF = 8;
  localparam int SEL_W_DEF = 4;

  function automatic int instr_width(int pc_w, int sel_w);
    return 2 + sel_w + SPARE_W + pc_w;
  endfunction
endpackage

// File: rtl/seq_rst_sync.sv
module seq_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_n_i,
  output logic rst_sync_n_o
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk_i or negedge rst_n_i) begin
    if (!rst_n_i) chain_q <= '0;
    else          chain_q <= chain_d;
  end

  assign rst_sync_n_o = chain_q[STAGES-1];
endmodule

// File: rtl/seq_store.sv
module seq_store #(
  parameter int AW = 8,
  parameter int DW = 16
) (
  input  logic          clk_i,
  input  logic          wr_en_i,
  input  logic [AW-1:0] wr_addr_i,
  input  logic [DW-1:0] wr_data_i,
  input  logic [AW-1:0] rd_addr_i,
  output logic [DW-1:0] rd_data_o
);
  localparam int DEPTH = 2 ** AW;

  logic [DW-1:0] mem_q [DEPTH];

  // No reset: the store is loaded through the write port
  always_ff @(posedge clk_i) begin
    if (wr_en_i) mem_q[wr_addr_i] <= wr_data_i;
  end

  assign rd_data_o = mem_q[rd_addr_i];
endmodule

// File: rtl/seq_cond_sel.sv
module seq_cond_sel #(
  parameter int SEL_W = 4
) (
  input  logic [2**SEL_W-1:0] cond_i,
  input  logic [SEL_W-1:0]    sel_i,
  output logic [2**SEL_W-1:0] cond_eff_o,
  output logic                hit_o
);
  localparam int N_SLOT = 2 ** SEL_W;
  localparam int TRUE_SLOT = N_SLOT - 1;

  for (genvar s = 0; s < N_SLOT; s++) begin : g_slot
    if (s == TRUE_SLOT) begin : g_true
      assign cond_eff_o[s] = 1'b1;
    end else begin : g_pass
      assign cond_eff_o[s] = cond_i[s];
    end
  end

  assign hit_o = cond_eff_o[sel_i];

  // The raw top slot is replaced by a constant
  logic unused_top;
  assign unused_top = cond_i[TRUE_SLOT];
endmodule

// File: rtl/seq_pc.sv
module seq_pc #(
  parameter int PC_W = 8
) (
  input  logic            clk_i,
  input  logic            rst_n_i,
  input  logic            load_i,
  input  logic [PC_W-1:0] target_i,
  output logic [PC_W-1:0] pc_o
);
  logic [PC_W-1:0] pc_q;
  logic [PC_W-1:0] pc_d;

  always_comb begin
    if (load_i) pc_d = target_i;
    else        pc_d = pc_q + 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_n_i) begin
    if (!rst_n_i) pc_q <= '0;
    else          pc_q <= pc_d;
  end

  assign pc_o = pc_q;
endmodule

// File: rtl/micro_sequencer.sv
module micro_sequencer #(
  parameter int PC_W  = seq_pkg::PC_W_DEF,
  parameter int SEL_W = seq_pkg::SEL_W_DEF
) (
  input  logic                                         clk_i,
  input  logic                                         rst_n_i,
  input  logic [2**SEL_W-1:0]                          cond_i,
  output logic [seq_pkg::instr_width(PC_W, SEL_W)-2:0] ctrl_o,
  input  logic                                         wr_en_i,
  input  logic [PC_W-1:0]                              wr_addr_i,
  input  logic [seq_pkg::instr_width(PC_W, SEL_W)-1:0] wr_data_i
);
  localparam int INSTR_W = seq_pkg::instr_width(PC_W, SEL_W);
  localparam int CTRL_W  = INSTR_W - 1;
  localparam int N_SLOT  = 2 ** SEL_W;
  localparam int KIND_B  = INSTR_W - 1;
  localparam int POL_B   = INSTR_W - 2;
  localparam int SEL_HI  = INSTR_W - 3;

  logic               rst_sync_n;
  logic [PC_W-1:0]    pc_q;
  logic [INSTR_W-1:0] instr_w;
  logic [N_SLOT-1:0]  cond_w;
  logic               cond_hit;
  logic               is_jump;
  logic               jump_take;
  logic               ctrl_en;
  logic [CTRL_W-1:0]  ctrl_q;

  seq_rst_sync #(.STAGES(2)) u_rst (
    .clk_i        (clk_i),
    .rst_n_i      (rst_n_i),
    .rst_sync_n_o (rst_sync_n)
  );

  seq_store #(.AW(PC_W), .DW(INSTR_W)) u_store (
    .clk_i     (clk_i),
    .wr_en_i   (wr_en_i),
    .wr_addr_i (wr_addr_i),
    .wr_data_i (wr_data_i),
    .rd_addr_i (pc_q),
    .rd_data_o (instr_w)
  );

  seq_cond_sel #(.SEL_W(SEL_W)) u_cond (
    .cond_i     (cond_i),
    .sel_i      (instr_w[SEL_HI -: SEL_W]),
    .cond_eff_o (cond_w),
    .hit_o      (cond_hit)
  );

  always_comb begin
    is_jump   = instr_w[KIND_B];
    jump_take = is_jump && (cond_hit == instr_w[POL_B]);
    ctrl_en   = !is_jump;
  end

  seq_pc #(.PC_W(PC_W)) u_pc (
    .clk_i    (clk_i),
    .rst_n_i  (rst_sync_n),
    .load_i   (jump_take),
    .target_i (instr_w[PC_W-1:0]),
    .pc_o     (pc_q)
  );

  always_ff @(posedge clk_i or negedge rst_sync_n) begin
    if (!rst_sync_n)  ctrl_q <= '0;
    else if (ctrl_en) ctrl_q <= instr_w[CTRL_W-1:0];
  end

  assign ctrl_o = ctrl_q;
endmodule

// File: rtl/seq_checker.sv
module seq_checker #(
  parameter int PC_W  = 8,
  parameter int SEL_W = 4
) (
  input logic                                         clk,
  input logic                                         rst_n,
  input logic [PC_W-1:0]                              pc,
  input logic [seq_pkg::instr_width(PC_W, SEL_W)-1:0] instr,
  input logic [2**SEL_W-1:0]                          cond,
  input logic [seq_pkg::instr_width(PC_W, SEL_W)-2:0] ctrl
);
  localparam int INSTR_W = seq_pkg::instr_width(PC_W, SEL_W);
  localparam int CTRL_W  = INSTR_W - 1;
  localparam int MSB     = INSTR_W - 1;
  localparam int SEL_HI  = INSTR_W - 3;

  // R2
  out_latch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !instr[MSB] |=> (ctrl == $past(instr[CTRL_W-1:0])));

  // R2
  out_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !instr[MSB] |=> (pc == PC_W'($past(pc) + 1'b1)));

  // R5
  jump_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    instr[MSB] |=> $stable(ctrl));

  // R3
  jump_taken_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (instr[MSB] && (cond[instr[SEL_HI -: SEL_W]] == instr[MSB-1]))
      |=> (pc == $past(instr[PC_W-1:0])));

  // R3
  jump_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (instr[MSB] && (cond[instr[SEL_HI -: SEL_W]] != instr[MSB-1]))
      |=> (pc == PC_W'($past(pc) + 1'b1)));

  // R6
  always_true_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (instr[MSB] && instr[MSB-1] && (&instr[SEL_HI -: SEL_W]))
      |=> (pc == $past(instr[PC_W-1:0])));
endmodule

bind micro_sequencer seq_checker #(.PC_W(PC_W), .SEL_W(SEL_W)) u_chk (
  .clk   (clk_i),
  .rst_n (rst_sync_n),
  .pc    (pc_q),
  .instr (instr_w),
  .cond  (cond_w),
  .ctrl  (ctrl_o)
);

// File: tb/sim_micro_sequencer.sv
module sim_micro_sequencer;
  localparam int PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [15:0] cond;
  logic [14:0] ctrl;
  logic        wr_en;
  logic [7:0]  wr_addr;
  logic [15:0] wr_data;

  int checks = 0;
  int errors = 0;

  always #(PERIOD/2) clk = ~clk;

  micro_sequencer u0 (
    .clk_i     (clk),
    .rst_n_i   (rst_n),
    .cond_i    (cond),
    .ctrl_o    (ctrl),
    .wr_en_i   (wr_en),
    .wr_addr_i (wr_addr),
    .wr_data_i (wr_data)
  );

  function automatic logic [14:0] pat(int a);
    return 15'((a * 37 + 5) & 16'h7fff);
  endfunction

  function automatic logic [15:0] op_out(logic [14:0] v);
    return {1'b0, v};
  endfunction

  function automatic logic [15:0] op_jmp(logic pol, logic [3:0] sel,
                                         logic [1:0] spare, logic [7:0] tgt);
    return {1'b1, pol, sel, spare, tgt};
  endfunction

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic check(string req, logic [14:0] act, logic [14:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: ctrl_o=%h expected %h", req, act, exp);
    end
  endtask

  task automatic put(logic [7:0] a, logic [15:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    step();
    wr_en = 1'b0;
  endtask

  task automatic enter_reset();
    rst_n = 1'b0;
    #1;
    check("R1 async clear", ctrl, 15'h0);
    @(negedge clk);
  endtask

  // releases reset; after return the next step executes address 0
  task automatic leave_reset();
    rst_n = 1'b1;
    step();
    check("R1 sync release edge 1", ctrl, 15'h0);
    step();
    check("R1 sync release edge 2", ctrl, 15'h0);
  endtask

  initial begin
    #(PERIOD * 200000);
    errors++;
    $display("FAIL watchdog: run did not end, actual=hung expected=done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    rst_n = 1'b0; cond = '0; wr_en = 1'b0; wr_addr = '0; wr_data = '0;
    @(negedge clk);
    step();
    check("R1 reset value", ctrl, 15'h0);

    // R2 / R7: straight-line program over all addresses, with wrap
    for (int a = 0; a < 256; a++) put(8'(a), op_out(pat(a)));
    leave_reset();
    for (int k = 0; k < 300; k++) begin
      step();
      check((k >= 256) ? "R7 wrap" : "R2 output", ctrl, pat(k % 256));
    end

    // R3 / R4 / R5 / R6: jump sweep
    for (int s = 0; s < 16; s++) begin
      for (int p = 0; p < 2; p++) begin
        for (int c = 0; c < 2; c++) begin
          logic eff;
          logic [14:0] exp;
          enter_reset();
          put(8'h00, op_out(15'h0abc));
          put(8'h01, op_jmp(p[0], 4'(s), {1'(s), p[0]}, 8'h40));
          put(8'h02, op_out(15'h1111));
          put(8'h40, op_out(15'h2222));
          cond = c[0] ? (16'h1 << s) : ~(16'h1 << s);
          eff  = (s == 15) ? 1'b1 : c[0];
          exp  = (eff == p[0]) ? 15'h2222 : 15'h1111;
          leave_reset();
          step();
          check("R2 first word", ctrl, 15'h0abc);
          step();
          check("R5 hold on jump", ctrl, 15'h0abc);
          step();
          if (s == 15) check("R6 slot always true", ctrl, exp);
          else         check("R3 R4 jump decision", ctrl, exp);
        end
      end
    end

    // R8: write into the address being executed
    enter_reset();
    cond = '0;
    put(8'h00, op_out(15'h0001));
    put(8'h01, op_out(15'h0002));
    put(8'h02, op_jmp(1'b1, 4'hf, 2'b00, 8'h00));
    leave_reset();
    step();
    check("R8 before write", ctrl, 15'h0001);
    wr_en = 1'b1; wr_addr = 8'h01; wr_data = op_out(15'h7777);
    step();
    wr_en = 1'b0;
    check("R8 old word executes", ctrl, 15'h0002);
    step();
    check("R8 loop jump holds", ctrl, 15'h0002);
    step();
    check("R8 back at address 0", ctrl, 15'h0001);
    step();
    check("R8 new word executes", ctrl, 15'h7777);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule